// File: doc/BRIEF.md
# Colour Subcarrier Phase Synthesizer with Field-Aligned Realignment

This block produces the colour subcarrier phase for a video encoder. A 32-bit phase accumulator advances once per pixel clock by a 32-bit frequency word. The frequency word is held in a register that comes out of reset with the NTSC default value 0x21F07C16 and that a host can overwrite with a one-cycle write strobe. The full phase word and its upper bits are presented at the outputs, ready to address a sine table that lies outside this block.

Clock frequency drift makes the subcarrier-to-sync phase wander over time, so the accumulator can be pulled back to its field-0 value, which is zero, at a field start. Three policies are selectable. The automatic policy realigns at the first field of every colour sequence: four fields for NTSC and eight for PAL. The armed policy realigns only when a request has been made, and the request is held until the next field start. The tracking policy never realigns, so the phase simply follows the incoming timing. When the encoder runs from an external real-time timing source, the automatic realignment is suppressed.

Top module: `subc_dds_top`

## Requirements
- R1: While `rst` is high, the phase reads 0 and the frequency word register is loaded with 0x21F07C16. On the first clock after reset is released, the phase becomes 0x21F07C16.
- R2: On each clock that does not realign, the phase becomes the previous phase plus the current frequency word, modulo 2^32.
- R3: A word presented with `freq_wr` high is stored at that clock edge. The increment at that same edge still uses the old word, and the new word is used from the following edge on. The phase is never set back by a write.
- R4: `phase_top_o` always equals the upper TOP_W bits (default 10, bits 31..22) of `phase_o`.
- R5: In mode 2'b00 (automatic) with `pal_sel`=0 and `ext_timing`=0, a clock with `field_start` high and `field_num[1:0]`==0 sets the phase to 0. Field starts with any other field number do not realign.
- R6: In mode 2'b00 with `pal_sel`=1 and `ext_timing`=0, only a field start with `field_num`==3'd0 realigns. Field numbers 4 and the other non-zero values do not.
- R7: In mode 2'b00 with `ext_timing`=1, no field start realigns, whatever the field number.
- R8: In mode 2'b01 (armed), a `reset_req` pulse made during a field causes the phase to be 0 after the next `field_start` clock. A request given on the same clock as `field_start` is applied at that field start.
- R9: In mode 2'b01 with no request pending, field starts never realign, including field number 0.
- R10: In modes 2'b10 and 2'b11 (tracking), the phase is never realigned, even when requests are made.
- R11: A pending request is cleared by any field start. After one realigning field start, the next field start with no new request does not realign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| field_start | input | 1 | One-cycle pulse on the first clock of a field |
| field_num | input | 3 | Number of the field that is starting (0..7) |
| pal_sel | input | 1 | 0 selects a 4-field sequence, 1 selects an 8-field sequence |
| ph_mode | input | 2 | Realignment policy: 00 automatic, 01 armed, 10/11 tracking |
| ext_timing | input | 1 | External real-time timing source active; suppresses automatic realignment |
| reset_req | input | 1 | Request for a realignment at the next field start |
| freq_wr | input | 1 | Write strobe for the frequency word |
| freq_in | input | 32 | New frequency word |
| phase_o | output | 32 | Accumulated subcarrier phase |
| phase_top_o | output | 10 | Upper phase bits for the sine lookup |

## Verification
The bench checks the exact clock at which a new frequency word begins to count. A design that applies the word one edge early or one edge late leaves every later phase value off by a whole word. It sweeps field numbers 0..7 under both sequence lengths, which catches a decoder that tests the wrong field bits, for example one that lets PAL field 4 realign. It covers requests issued mid-field and requests issued on the field-start clock itself. It also checks that a request is consumed, because a latch that never clears would realign on every later field. Tracking modes, and the automatic mode under external timing, are driven with requests and field-0 starts to show that the phase runs on without a break.

// File: rtl/subc_dds_pkg.sv
package subc_dds_pkg;

  localparam int FIELD_W = 3;

  typedef enum logic [1:0] {
    PH_AUTO      = 2'b00,
    PH_ARMED     = 2'b01,
    PH_TRACK     = 2'b10,
    PH_TRACK_ALT = 2'b11
  } ph_mode_e;

  localparam logic [31:0] NTSC_FREQ_DEFAULT = 32'h21F07C16;

  // First field of a colour sequence: 4 fields (NTSC) or 8 fields (PAL)
  function automatic logic seq_first_field(input logic pal,
                                           input logic [FIELD_W-1:0] fnum);
    if (pal) return (fnum == '0);
    else     return (fnum[1:0] == 2'b00);
  endfunction

endpackage

// File: rtl/subc_freq_reg.sv
module subc_freq_reg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] INIT = 32'h21F07C16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] freq_q
);

  always_ff @(posedge clk) begin
    if (rst)     freq_q <= INIT;
    else if (wr) freq_q <= din;
  end

  // R1: reset loads the power-on word
  assert_reset_word_R1: assert property (@(posedge clk) rst |=> (freq_q == INIT));

  // R3: the word holds when no write is made
  assert_word_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(freq_q));

endmodule

// File: rtl/subc_phase_ctrl.sv
module subc_phase_ctrl
  import subc_dds_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               field_start,
  input  logic [FIELD_W-1:0] field_num,
  input  logic               pal_sel,
  input  logic [1:0]         mode,
  input  logic               ext_timing,
  input  logic               reset_req,
  output logic               realign
);

  ph_mode_e mode_e;
  logic     req_pend;
  logic     auto_hit;
  logic     armed_hit;

  assign mode_e = ph_mode_e'(mode);

  // request latch: held until the next field start, cleared there
  always_ff @(posedge clk) begin
    if (rst)              req_pend <= 1'b0;
    else if (field_start) req_pend <= 1'b0;
    else if (reset_req)   req_pend <= 1'b1;
  end

  always_comb begin
    auto_hit  = (mode_e == PH_AUTO) && !ext_timing && seq_first_field(pal_sel, field_num);
    armed_hit = (mode_e == PH_ARMED) && (req_pend || reset_req);
    realign   = field_start && (auto_hit || armed_hit);
  end

  // R5: realignment only happens on a field start
  assert_realign_on_start_R5: assert property (@(posedge clk) disable iff (rst)
    realign |-> field_start);

  // R7: external timing blocks automatic realignment
  assert_ext_blocks_auto_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_e == PH_AUTO && ext_timing) |-> !realign);

  // R10: tracking modes never realign
  assert_track_free_R10: assert property (@(posedge clk) disable iff (rst)
    (mode_e == PH_TRACK || mode_e == PH_TRACK_ALT) |-> !realign);

  // R11: the latch is empty after a field start
  assert_req_cleared_R11: assert property (@(posedge clk) disable iff (rst)
    field_start |=> !req_pend);

endmodule

// File: rtl/subc_phase_acc.sv
module subc_phase_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         realign,
  input  logic [W-1:0] freq,
  output logic [W-1:0] phase_q
);

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= '0;
    else if (realign) phase_q <= '0;
    else              phase_q <= phase_q + freq;
  end

  // R5: a realignment leaves the field-0 phase
  assert_realign_zero_R5: assert property (@(posedge clk) disable iff (rst)
    realign |=> (phase_q == '0));

  // R2: otherwise the phase advances by the word, wrapping
  assert_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !realign |=> (phase_q == W'($past(phase_q) + $past(freq))));

endmodule

// File: rtl/subc_dds_top.sv
module subc_dds_top
  import subc_dds_pkg::*;
#(
  parameter int          ACC_W     = 32,
  parameter int          TOP_W     = 10,
  parameter logic [ACC_W-1:0] FREQ_INIT = NTSC_FREQ_DEFAULT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               field_start,
  input  logic [2:0]         field_num,
  input  logic               pal_sel,
  input  logic [1:0]         ph_mode,
  input  logic               ext_timing,
  input  logic               reset_req,
  input  logic               freq_wr,
  input  logic [ACC_W-1:0]   freq_in,
  output logic [ACC_W-1:0]   phase_o,
  output logic [TOP_W-1:0]   phase_top_o
);

  localparam int TOP_LSB = ACC_W - TOP_W;

  logic [ACC_W-1:0] freq_q;
  logic             realign;

  generate
    if (TOP_W > ACC_W || TOP_W < 1) begin : g_bad_top
      initial $error("TOP_W out of range");
    end
  endgenerate

  subc_freq_reg #(.W(ACC_W), .INIT(FREQ_INIT)) u_freq (
    .clk    (clk),
    .rst    (rst),
    .wr     (freq_wr),
    .din    (freq_in),
    .freq_q (freq_q)
  );

  subc_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .field_start (field_start),
    .field_num   (field_num),
    .pal_sel     (pal_sel),
    .mode        (ph_mode),
    .ext_timing  (ext_timing),
    .reset_req   (reset_req),
    .realign     (realign)
  );

  subc_phase_acc #(.W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .realign (realign),
    .freq    (freq_q),
    .phase_q (phase_o)
  );

  assign phase_top_o = phase_o[ACC_W-1:TOP_LSB];

  // R1: phase sits at zero through reset
  assert_reset_phase_R1: assert property (@(posedge clk) rst |=> (phase_o == '0));

endmodule

// File: tb/tb_subc_dds_top.sv
module tb_subc_dds_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        field_start = 1'b0;
  logic [2:0]  field_num = 3'd0;
  logic        pal_sel = 1'b0;
  logic [1:0]  ph_mode = 2'b10;
  logic        ext_timing = 1'b0;
  logic        reset_req = 1'b0;
  logic        freq_wr = 1'b0;
  logic [31:0] freq_in = 32'h0;
  logic [31:0] phase_o;
  logic [9:0]  phase_top_o;

  always #5 clk = ~clk;

  subc_dds_top dut (
    .clk(clk), .rst(rst), .field_start(field_start), .field_num(field_num),
    .pal_sel(pal_sel), .ph_mode(ph_mode), .ext_timing(ext_timing),
    .reset_req(reset_req), .freq_wr(freq_wr), .freq_in(freq_in),
    .phase_o(phase_o), .phase_top_o(phase_top_o)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag = "R2";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // reference model
  longint unsigned m_phase = 0;
  longint unsigned m_freq  = 0;
  bit              m_pend  = 0;

  always @(posedge clk) begin
    bit hit;
    if (rst) begin
      m_phase = 0;
      m_freq  = 64'h21F07C16;
      m_pend  = 0;
    end else begin
      hit = 0;
      if (field_start) begin
        if (ph_mode == 2'b00 && !ext_timing)
          hit = pal_sel ? (field_num == 0) : ((field_num % 4) == 0);
        else if (ph_mode == 2'b01)
          hit = m_pend || reset_req;
      end
      m_phase = hit ? 0 : ((m_phase + m_freq) % 64'h1_0000_0000);
      if (freq_wr) m_freq = freq_in;
      if (field_start) m_pend = 0;
      else if (reset_req) m_pend = 1;
    end
  end

  task automatic chk(input string r, input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(tag, phase_o, m_phase);
      chk("R4", phase_top_o, m_phase >> 22);
    end
  end

  // one field: start pulse then idle cycles; checks realign outcome
  task automatic field(input int fn, input bit exp_zero, input string r,
                       input bit req_same = 0);
    @(negedge clk);
    field_start = 1'b1;
    field_num   = 3'(fn);
    reset_req   = req_same;
    @(negedge clk);
    field_start = 1'b0;
    reset_req   = 1'b0;
    checks++;
    if ((phase_o == 0) != exp_zero) begin
      fails++;
      $display("FAIL %s field %0d realign got=%0d exp=%0d", r, fn, phase_o == 0, exp_zero);
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_req();
    @(negedge clk); reset_req = 1'b1;
    @(negedge clk); reset_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    longint unsigned p0, p1, p2;
    repeat (4) @(negedge clk);
    chk("R1", phase_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", phase_o, 32'h21F07C16);
    cmp_on = 1'b1;

    // R2 free run with wrap
    tag = "R2";
    repeat (40) @(negedge clk);

    // R3 write timing
    tag = "R3";
    p0 = phase_o;
    freq_in = 32'h0123_4567;
    freq_wr = 1'b1;
    @(negedge clk);
    freq_wr = 1'b0;
    p1 = phase_o;
    chk("R3", p1, (p0 + 64'h21F07C16) % 64'h1_0000_0000);
    @(negedge clk);
    p2 = phase_o;
    chk("R3", p2, (p1 + 64'h0123_4567) % 64'h1_0000_0000);
    repeat (10) @(negedge clk);

    // R5 automatic, 4-field sequence
    tag = "R5"; ph_mode = 2'b00; pal_sel = 1'b0;
    for (int f = 0; f < 8; f++) field(f, (f % 4) == 0, "R5");

    // R6 automatic, 8-field sequence
    tag = "R6"; pal_sel = 1'b1;
    for (int f = 0; f < 8; f++) field(f, f == 0, "R6");

    // R7 external timing suppresses
    tag = "R7"; ext_timing = 1'b1; pal_sel = 1'b0;
    for (int f = 0; f < 8; f++) field(f, 1'b0, "R7");
    ext_timing = 1'b0;

    // R9 armed, nothing requested
    tag = "R9"; ph_mode = 2'b01;
    field(0, 1'b0, "R9");
    field(4, 1'b0, "R9");

    // R8 mid-field request, then R11 consumed
    tag = "R8";
    pulse_req();
    field(3, 1'b1, "R8");
    tag = "R11";
    field(5, 1'b0, "R11");
    // R8 request on the field-start clock
    tag = "R8";
    field(6, 1'b1, "R8", 1'b1);
    tag = "R11";
    field(7, 1'b0, "R11");

    // R10 tracking ignores requests
    tag = "R10"; ph_mode = 2'b10;
    pulse_req();
    field(0, 1'b0, "R10");
    ph_mode = 2'b11;
    pulse_req();
    field(0, 1'b0, "R10", 1'b1);

    // R2 maximal word wrap, R3 write on a realign edge
    tag = "R2";
    freq_in = 32'hFFFF_FFFF; freq_wr = 1'b1;
    @(negedge clk); freq_wr = 1'b0;
    repeat (20) @(negedge clk);
    tag = "R3"; ph_mode = 2'b00; pal_sel = 1'b1;
    @(negedge clk);
    field_start = 1'b1; field_num = 3'd0; freq_wr = 1'b1; freq_in = 32'h0000_1000;
    @(negedge clk);
    field_start = 1'b0; freq_wr = 1'b0;
    chk("R3", phase_o, 0);
    @(negedge clk);
    chk("R3", phase_o, 32'h0000_1000);
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule